// File: doc/BRIEF.md
# Load Ordering Violation Detector

This block tracks in-flight loads of an out-of-order core in program order and catches loads that read memory too early. A load may go to memory as soon as its own address is known, even while older stores still have unknown addresses. Each time an older store resolves its address, the block compares that byte range against every younger load that has already executed. If any of them overlap, it reports the oldest such load as the point from which the pipeline must restart.

Loads are appended at the tail of a circular buffer. They record their address and access size when they issue, and they leave from the head when the retire signal is asserted. A flush input with a restart tag removes every entry at or after that tag. A conservative mode holds a load back while an older store still has an unknown address, so no violation can arise for that load. Age tags are sequence numbers compared modulo 2^TAG_W. The buffer depth must be a power of two.

Top module: `ldord_guard`

## Requirements
- R1: After reset the buffer is empty, `full` is 0, `viol_valid` is 0, `alloc_idx` is 0 and `issue_ok` is 1 while `cons_mode` is 0.
- R2: An accepted allocation writes the entry at index `alloc_idx` and advances the tail by one. `full` is 1 exactly when DEPTH entries are held. An allocation while `full` is 1 is ignored.
- R3: An issue to a held entry that has not yet executed records the address and size and marks the entry executed. An issue to a free or already executed entry is ignored.
- R4: When `st_valid` is 1, `viol_valid` is 1 in the next cycle exactly when a held, executed, younger load overlaps the store. Size code s (0..3) means 2^s bytes. Two accesses overlap when the byte ranges [a, a+n) intersect, judged on address and size together.
- R5: Only loads younger than the store count. A tag is older when (older − younger) mod 2^TAG_W has its top bit set. Loads with a tag equal to or older than the store tag are never reported.
- R6: A held load that has not yet executed is never reported.
- R7: When several loads conflict with one store, `viol_tag` names the one that is oldest in program order, even across wraparound of the buffer index and of the tag.
- R8: A flush removes, in the same cycle, every entry whose tag equals or is younger than `flush_tag`. The tail moves back to just after the last surviving entry. Removed loads are never reported. Allocation is ignored in a flush cycle.
- R9: `retire` removes the head entry only when that entry has executed. Otherwise `retire` has no effect.
- R10: With `cons_mode` set, `issue_ok` is 0 when `unres_valid` is 1 and `unres_tag` is older than the tag of the entry at `issue_idx`. An issue while `issue_ok` is 0 is ignored. With `cons_mode` clear, `issue_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Append a load at the tail |
| alloc_tag | input | TAG_W | Age tag of the appended load |
| alloc_idx | output | log2(DEPTH) | Index the next allocation will take |
| full | output | 1 | Buffer holds DEPTH loads |
| issue_valid | input | 1 | A load sends its address to memory |
| issue_idx | input | log2(DEPTH) | Buffer index of the issuing load |
| issue_addr | input | ADDR_W | Byte address of the issuing load |
| issue_size | input | 2 | Size code, 2^code bytes |
| issue_ok | output | 1 | Issue at `issue_idx` is permitted |
| cons_mode | input | 1 | Wait for older store addresses before issue |
| unres_valid | input | 1 | Some store has an unknown address |
| unres_tag | input | TAG_W | Tag of the oldest store with unknown address |
| st_valid | input | 1 | A store resolves its address |
| st_tag | input | TAG_W | Age tag of the resolving store |
| st_addr | input | ADDR_W | Byte address of the resolving store |
| st_size | input | 2 | Size code of the resolving store |
| retire | input | 1 | Pop the head load |
| flush_valid | input | 1 | Remove loads at or after `flush_tag` |
| flush_tag | input | TAG_W | Restart tag of the flush |
| viol_valid | output | 1 | Ordering violation found by last store |
| viol_tag | output | TAG_W | Tag of the oldest violating load |

## Verification
The assertions check on every cycle that occupancy stays within the depth and that an empty buffer holds no live entry. They also check that flushed entries are gone in the next cycle, that the age-ordered selection grants at most one entry, and that any reported load is younger than the store that found it. Only the bench scenarios can show that overlap is decided correctly for every pair of sizes and offsets, that the oldest conflicting load is chosen across wraparound, and that retire of an unexecuted head, issue to a blocked entry and allocation into a full buffer leave the state unchanged.

// File: rtl/ldord_pkg.sv
package ldord_pkg;
  localparam int TAG_W  = 6;
  localparam int ADDR_W = 16;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [ADDR_W:0]   span_t;
  typedef logic [1:0]        size_t;

  // a is older than b in modular sequence order
  function automatic logic tag_older(tag_t a, tag_t b);
    tag_t d;
    d = a - b;
    return d[TAG_W-1];
  endfunction

  // one past the last byte touched, widened so it never wraps
  function automatic span_t span_end(addr_t a, size_t s);
    return {1'b0, a} + (span_t'(1) << s);
  endfunction

  function automatic logic bytes_overlap(addr_t a, size_t sa, addr_t b, size_t sb);
    return ({1'b0, a} < span_end(b, sb)) && ({1'b0, b} < span_end(a, sa));
  endfunction
endpackage

// File: rtl/ldord_entry.sv
module ldord_entry
  import ldord_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  alloc_we,
  input  tag_t  alloc_tag,
  input  logic  issue_we,
  input  addr_t issue_addr,
  input  size_t issue_size,
  input  logic  clear,
  input  logic  st_valid,
  input  tag_t  st_tag,
  input  addr_t st_addr,
  input  size_t st_size,
  input  logic  flush_valid,
  input  tag_t  flush_tag,
  output logic  vld,
  output logic  exe,
  output tag_t  tag,
  output logic  hit,
  output logic  kill
);
  addr_t addr_q;
  size_t size_q;

  assign hit  = vld && exe && st_valid && tag_older(st_tag, tag) &&
                bytes_overlap(addr_q, size_q, st_addr, st_size);
  assign kill = flush_valid && vld && !tag_older(tag, flush_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      exe    <= 1'b0;
      tag    <= '0;
      addr_q <= '0;
      size_q <= '0;
    end else if (clear) begin
      vld <= 1'b0;
      exe <= 1'b0;
    end else if (alloc_we) begin
      vld <= 1'b1;
      exe <= 1'b0;
      tag <= alloc_tag;
    end else if (issue_we) begin
      exe    <= 1'b1;
      addr_q <= issue_addr;
      size_q <= issue_size;
    end
  end

  // R8
  kill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !vld);
endmodule

// File: rtl/ldord_oldest.sv
module ldord_oldest #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] req,
  input  logic [IDX_W-1:0] head,
  output logic             any,
  output logic [DEPTH-1:0] grant,
  output logic [IDX_W-1:0] sel
);
  always_comb begin
    logic             found;
    logic [IDX_W-1:0] pos;
    found = 1'b0;
    grant = '0;
    sel   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      pos = head + IDX_W'(k);
      if (!found && req[pos]) begin
        found      = 1'b1;
        grant[pos] = 1'b1;
        sel        = pos;
      end
    end
    any = found;
  end

  // R7
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (req != '0)));
endmodule

// File: rtl/ldord_guard.sv
module ldord_guard
  import ldord_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [TAG_W-1:0]  alloc_tag,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic              full,
  input  logic              issue_valid,
  input  logic [IDX_W-1:0]  issue_idx,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [1:0]        issue_size,
  output logic              issue_ok,
  input  logic              cons_mode,
  input  logic              unres_valid,
  input  logic [TAG_W-1:0]  unres_tag,
  input  logic              st_valid,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              retire,
  input  logic              flush_valid,
  input  logic [TAG_W-1:0]  flush_tag,
  output logic              viol_valid,
  output logic [TAG_W-1:0]  viol_tag
);
  logic [PTR_W-1:0] head_q, tail_q, occ, keep;
  logic [IDX_W-1:0] head_idx, tail_idx, pick_idx;
  logic [DEPTH-1:0] vld_v, exe_v, hit_v, kill_v, live_hit, pick_oh;
  tag_t             tag_a [DEPTH];
  tag_t             issue_tag;
  logic             alloc_go, issue_go, retire_go, pick_any;

  assign head_idx  = head_q[IDX_W-1:0];
  assign tail_idx  = tail_q[IDX_W-1:0];
  assign occ       = tail_q - head_q;
  assign full      = (occ == PTR_W'(DEPTH));
  assign alloc_idx = tail_idx;

  assign issue_tag = tag_a[issue_idx];
  assign issue_ok  = !cons_mode || !unres_valid || tag_older(issue_tag, unres_tag);

  assign alloc_go  = alloc_valid && !full && !flush_valid;
  assign issue_go  = issue_valid && issue_ok && vld_v[issue_idx] &&
                     !exe_v[issue_idx] && !kill_v[issue_idx];
  assign retire_go = retire && vld_v[head_idx] && exe_v[head_idx] && !kill_v[head_idx];
  assign keep      = PTR_W'($countones(vld_v & ~kill_v));
  assign live_hit  = hit_v & ~kill_v;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    ldord_entry u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_we   (alloc_go && (tail_idx == IDX_W'(i))),
      .alloc_tag  (alloc_tag),
      .issue_we   (issue_go && (issue_idx == IDX_W'(i))),
      .issue_addr (issue_addr),
      .issue_size (issue_size),
      .clear      (kill_v[i] || (retire_go && (head_idx == IDX_W'(i)))),
      .st_valid   (st_valid),
      .st_tag     (st_tag),
      .st_addr    (st_addr),
      .st_size    (st_size),
      .flush_valid(flush_valid),
      .flush_tag  (flush_tag),
      .vld        (vld_v[i]),
      .exe        (exe_v[i]),
      .tag        (tag_a[i]),
      .hit        (hit_v[i]),
      .kill       (kill_v[i])
    );
  end

  ldord_oldest #(.DEPTH(DEPTH)) u_pick (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (live_hit),
    .head (head_idx),
    .any  (pick_any),
    .grant(pick_oh),
    .sel  (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q     <= '0;
      tail_q     <= '0;
      viol_valid <= 1'b0;
      viol_tag   <= '0;
    end else begin
      head_q     <= head_q + PTR_W'(retire_go);
      tail_q     <= flush_valid ? head_q + keep : tail_q + PTR_W'(alloc_go);
      viol_valid <= pick_any;
      viol_tag   <= tag_a[pick_idx];
    end
  end

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PTR_W'(DEPTH));

  // R8
  empty_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (vld_v == '0));

  // R5
  viol_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> ($past(st_valid) && tag_older($past(st_tag), viol_tag)));
endmodule

// File: tb/ldord_guard_tb.sv
module ldord_guard_tb;
  import ldord_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, issue_valid = 0, cons_mode = 0, unres_valid = 0;
  logic st_valid = 0, retire = 0, flush_valid = 0;
  tag_t alloc_tag = '0, unres_tag = '0, st_tag = '0, flush_tag = '0;
  logic [IW-1:0] issue_idx = '0;
  addr_t issue_addr = '0, st_addr = '0;
  size_t issue_size = '0, st_size = '0;
  logic [IW-1:0] alloc_idx;
  logic full, issue_ok, viol_valid;
  tag_t viol_tag;

  int checks = 0, failures = 0;
  int tb_head = 0, tb_tail = 0;
  int idx_of [64];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldord_guard #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_idx(alloc_idx), .full(full),
    .issue_valid(issue_valid), .issue_idx(issue_idx), .issue_addr(issue_addr),
    .issue_size(issue_size), .issue_ok(issue_ok),
    .cons_mode(cons_mode), .unres_valid(unres_valid), .unres_tag(unres_tag),
    .st_valid(st_valid), .st_tag(st_tag), .st_addr(st_addr), .st_size(st_size),
    .retire(retire), .flush_valid(flush_valid), .flush_tag(flush_tag),
    .viol_valid(viol_valid), .viol_tag(viol_tag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_alloc(int t);
    alloc_valid = 1; alloc_tag = tag_t'(t);
    idx_of[t] = tb_tail % DEPTH;
    tick();
    alloc_valid = 0;
    tb_tail++;
  endtask

  task automatic do_issue(int t, int a, int s);
    issue_valid = 1; issue_idx = IW'(idx_of[t]);
    issue_addr = addr_t'(a); issue_size = size_t'(s);
    tick();
    issue_valid = 0;
  endtask

  task automatic do_store(int t, int a, int s);
    st_valid = 1; st_tag = tag_t'(t); st_addr = addr_t'(a); st_size = size_t'(s);
    tick();
    st_valid = 0;
  endtask

  task automatic do_flush(int t, int kept);
    flush_valid = 1; flush_tag = tag_t'(t);
    tick();
    flush_valid = 0;
    tb_tail = tb_head + kept;
  endtask

  task automatic do_retire();
    retire = 1;
    tick();
    retire = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 viol", viol_valid, 0);
    chk("R1 full", full, 0);
    chk("R1 alloc_idx", alloc_idx, 0);
    chk("R1 issue_ok", issue_ok, 1);

    // R4 overlap sweep over both sizes and offsets; R5 younger store ignored
    for (int ls = 0; ls < 4; ls++) begin
      for (int ss = 0; ss < 4; ss++) begin
        for (int off = -8; off <= 8; off++) begin
          int sa = 100 + off;
          bit exp_hit = (100 < sa + (1 << ss)) && (sa < 100 + (1 << ls));
          do_alloc(10);
          do_issue(10, 100, ls);
          do_store(5, sa, ss);
          chk("R4 overlap", viol_valid, exp_hit);
          if (exp_hit) chk("R4 tag", viol_tag, 10);
          do_flush(10, 0);
        end
        do_alloc(10);
        do_issue(10, 100, ls);
        do_store(15, 100, ss);
        chk("R5 younger store", viol_valid, 0);
        do_store(10, 100, ss);
        chk("R5 equal tag", viol_valid, 0);
        do_flush(10, 0);
      end
    end

    // R6 unexecuted load not reported
    do_alloc(10);
    do_store(5, 100, 3);
    chk("R6 unexecuted", viol_valid, 0);
    // R3 re-issue to executed entry ignored: address stays 100
    do_issue(10, 100, 0);
    do_issue(10, 900, 0);
    do_store(5, 900, 0);
    chk("R3 reissue ignored", viol_valid, 0);
    do_store(5, 100, 0);
    chk("R3 issue recorded", viol_valid, 1);
    do_flush(10, 0);

    // R7 several conflicts: oldest reported
    for (int t = 20; t <= 24; t++) do_alloc(t);
    do_issue(21, 400, 2); do_issue(22, 402, 1); do_issue(24, 400, 0);
    do_store(19, 400, 3);
    chk("R7 oldest", viol_valid, 1);
    chk("R7 oldest tag", viol_tag, 21);
    do_store(21, 400, 3);
    chk("R7 next oldest tag", viol_tag, 22);
    do_flush(20, 0);

    // R2 fill with tag wraparound, R7 across wrap, R9 retire
    for (int k = 0; k < 16; k++) do_alloc((60 + k) % 64);
    chk("R2 full", full, 1);
    alloc_valid = 1; alloc_tag = tag_t'(12);
    tick();
    alloc_valid = 0;
    chk("R2 alloc when full ignored", full, 1);
    chk("R2 alloc_idx held", alloc_idx, tb_tail % DEPTH);
    do_issue(62, 200, 2);
    do_issue(2, 202, 0);
    do_store(61, 200, 3);
    chk("R7 wrap oldest", viol_tag, 62);
    do_store(63, 200, 3);
    chk("R7 tag wrap", viol_tag, 2);
    do_retire();
    chk("R9 unexecuted head kept", full, 1);
    do_issue(60, 300, 0);
    do_retire();
    tb_head++;
    chk("R9 executed head retired", full, 0);
    do_flush(61, 0);
    chk("R8 flush all rewinds tail", alloc_idx, tb_tail % DEPTH);

    // R8 partial flush
    for (int t = 30; t <= 35; t++) do_alloc(t);
    for (int t = 30; t <= 35; t++) do_issue(t, 500, 2);
    do_flush(33, 3);
    chk("R8 tail after flush", alloc_idx, tb_tail % DEPTH);
    do_store(32, 500, 2);
    chk("R8 flushed not reported", viol_valid, 0);
    do_store(29, 500, 2);
    chk("R8 survivor reported", viol_tag, 30);
    flush_valid = 1; flush_tag = tag_t'(40); alloc_valid = 1; alloc_tag = tag_t'(41);
    tick();
    flush_valid = 0; alloc_valid = 0;
    chk("R8 alloc in flush ignored", alloc_idx, tb_tail % DEPTH);
    do_flush(30, 0);

    // R10 conservative mode
    cons_mode = 1; unres_valid = 1; unres_tag = tag_t'(40);
    do_alloc(42);
    issue_idx = IW'(idx_of[42]);
    #1;
    chk("R10 blocked", issue_ok, 0);
    do_issue(42, 700, 2);
    do_store(40, 700, 2);
    chk("R10 blocked issue ignored", viol_valid, 0);
    unres_tag = tag_t'(45);
    #1;
    chk("R10 allowed", issue_ok, 1);
    do_issue(42, 700, 2);
    do_store(41, 700, 2);
    chk("R10 issued load checked", viol_tag, 42);
    cons_mode = 0; unres_tag = tag_t'(40);
    #1;
    chk("R10 mode off", issue_ok, 1);
    unres_valid = 0;
    do_flush(42, 0);
    chk("R1 empty again", full, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule